// File: doc/BRIEF.md
# Dual Interval Timer with Pulse Counting

This block is a peripheral timer unit holding two independent 16-bit down-counters behind a small CPU register bus (chip select, 4-bit register address, read and write strobes, 8-bit data). Each counter is loaded from a 16-bit latch. Software writes the low latch byte, then the high byte. The high-byte write copies the whole latch into the counter, clears that timer's flag and starts it.

Timer A runs either one-shot, signalling once and then wrapping silently, or free-running, reloading from its latch on every zero and signalling each time. Timer B either counts system clock cycles (interval mode) or counts falling edges on an external pin (pulse mode). The pin passes through a synchronizer and an edge detector. Each timer sets a flag when it reaches zero. A flag takes part in the active-low interrupt output only while its enable bit is set.

The register bus is a plain control interface with no back-pressure. A write takes effect on the clock edge at which `cs` and `wr` are high. A read returns data combinationally while `cs` is high. A read strobe (`rd`) is needed only for the read side effect of clearing a flag.

Top module: `dual_timer_unit`

## Requirements
- R1: After reset both counters and latches are 0, both timers are stopped, flags, enables and mode bits are 0, and `irq_n` is 1. A stopped counter stays at 0.
- R2: Writing the high count byte (address 1 for timer A, address 5 for timer B) loads the counter with {written byte, latch low byte}, clears that timer's flag and starts it. The low byte goes to the latch through address 0 (A) or 4 (B). A running counter then decreases by one on each of its ticks.
- R3: In one-shot mode (mode bit 0 = 0), timer A's flag (flag bit 0) is set on the tick that finds the count at 0, so N+1 clocks after a load of N. The counter wraps to 0xFFFF and the flag is not set again until the next start.
- R4: In free-running mode (mode bit 0 = 1), timer A reloads from its latch on the tick that finds the count at 0 and sets its flag each time, so every N+1 clocks. Latch writes at addresses 2 (low) and 3 (high) change only the latch and never the running count.
- R5: With mode bit 1 = 0, timer B ticks on every clock. Its flag (flag bit 1) is set N+1 clocks after a load of N, and it then wraps without flagging again.
- R6: With mode bit 1 = 1, timer B ticks once per falling edge of `pulse_in`, after a two-flop synchronizer. It does not change without such edges, and it sets flag bit 1 on the (N+1)th falling edge.
- R7: A read strobe at a timer's low count address (0 for A, 4 for B) clears that timer's flag. Writing the flag register (address 7) clears every flag whose data bit is 1.
- R8: Writing the enable register (address 8) with data bit 7 = 1 sets the enable bits marked 1 in bits 1:0. With bit 7 = 0 it clears them. Reading address 8 returns the enables in bits 1:0.
- R9: `irq_n` is 0 exactly while some flag and its enable bit are both 1. Flag register bit 7 reads the same condition, high when the interrupt is active.
- R10: Read map: 0/1 timer A count low/high, 2/3 timer A latch low/high, 4/5 timer B count low/high, 6 mode in bits 1:0, 7 flags in bits 1:0 plus the interrupt bit in bit 7, 8 enables. Reads with `cs` low return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Register bus chip select |
| addr | input | 4 | Register address |
| wr | input | 1 | Write strobe, acts at the clock edge |
| rd | input | 1 | Read strobe, applies flag-clearing side effects |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` while `cs` is high |
| pulse_in | input | 1 | External pulse input counted by timer B in pulse mode |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The embedded properties assume at most one register access per cycle, with `wr` and `rd` never high together. They also assume that `pulse_in` holds each level for at least two clock cycles, so the synchronizer sees every edge. The bench drives the bus from tasks that raise one strobe for exactly one edge and then drop `cs`. It always writes the low latch byte before the high one, and it holds every pulse level for four cycles. Flag, count and interrupt checks are sampled on the falling clock edge, counted from the edge that loaded the counter.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int DW = 8;
  localparam int CW = 2 * DW;
  localparam int AW = 4;
  localparam int NT = 2;
  localparam int TMR_A = 0;
  localparam int TMR_B = 1;
  localparam int EN_SET_BIT = DW - 1;
  localparam int IRQ_BIT = DW - 1;

  typedef enum logic [AW-1:0] {
    ADDR_A_CLO  = 4'd0,
    ADDR_A_CHI  = 4'd1,
    ADDR_A_LLO  = 4'd2,
    ADDR_A_LHI  = 4'd3,
    ADDR_B_CLO  = 4'd4,
    ADDR_B_CHI  = 4'd5,
    ADDR_MODE   = 4'd6,
    ADDR_FLAG   = 4'd7,
    ADDR_ENABLE = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic [NT-1:0] lat_lo_we;
    logic [NT-1:0] lat_hi_we;
    logic [NT-1:0] start;
    logic [NT-1:0] rd_clr;
    logic          mode_we;
    logic          flag_we;
    logic          en_we;
  } bus_strobe_t;
endpackage

// File: rtl/dt_regbus.sv
module dt_regbus
  import dt_pkg::*;
(
  input  logic          cs,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  output bus_strobe_t   stb
);
  logic wen;
  logic ren;

  assign wen = cs & wr;
  assign ren = cs & rd & ~wr;

  always_comb begin
    stb = '0;
    case (addr)
      ADDR_A_CLO: begin
        stb.lat_lo_we[TMR_A] = wen;
        stb.rd_clr[TMR_A]    = ren;
      end
      ADDR_A_CHI: begin
        stb.lat_hi_we[TMR_A] = wen;
        stb.start[TMR_A]     = wen;
      end
      ADDR_A_LLO: stb.lat_lo_we[TMR_A] = wen;
      ADDR_A_LHI: stb.lat_hi_we[TMR_A] = wen;
      ADDR_B_CLO: begin
        stb.lat_lo_we[TMR_B] = wen;
        stb.rd_clr[TMR_B]    = ren;
      end
      ADDR_B_CHI: begin
        stb.lat_hi_we[TMR_B] = wen;
        stb.start[TMR_B]     = wen;
      end
      ADDR_MODE:   stb.mode_we = wen;
      ADDR_FLAG:   stb.flag_we = wen;
      ADDR_ENABLE: stb.en_we   = wen;
      default: ;
    endcase
  end
endmodule

// File: rtl/dt_pulse_sync.sv
module dt_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic strike
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  // previous synchronized level high, current low: one falling edge
  assign strike = sh[STAGES] & ~sh[STAGES-1];

  a_r6_single_strike: assert property (@(posedge clk) disable iff (!rst_n)
    strike |=> !strike);
endmodule

// File: rtl/dt_countdown.sv
module dt_countdown
  import dt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          reload,
  input  logic          lat_lo_we,
  input  logic          lat_hi_we,
  input  logic          start,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] count,
  output logic [CW-1:0] latch,
  output logic          zero_evt
);
  logic running;
  logic armed;
  logic at_zero;

  assign at_zero  = (count == '0);
  assign zero_evt = running & tick & at_zero & ~start & (armed | reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= '0;
    end else begin
      if (lat_lo_we) latch[DW-1:0]  <= wdata;
      if (lat_hi_we) latch[CW-1:DW] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
      armed   <= 1'b0;
    end else if (start) begin
      count   <= {wdata, latch[DW-1:0]};
      running <= 1'b1;
      armed   <= 1'b1;
    end else if (running && tick) begin
      if (at_zero && reload) begin
        count <= latch;
      end else begin
        count <= count - 1'b1;
        if (at_zero) armed <= 1'b0;
      end
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> count == {$past(wdata), $past(latch[DW-1:0])});

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !start && !at_zero) |=> count == CW'($past(count) - 1'b1));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && !start && at_zero && reload) |=> count == $past(latch));

  a_r3_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !reload) |=> !armed);

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> $stable(count));
endmodule

// File: rtl/dual_timer_unit.sv
module dual_timer_unit
  import dt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          pulse_in,
  output logic          irq_n
);
  bus_strobe_t   stb;
  logic          strike;
  logic [NT-1:0] mode;
  logic [NT-1:0] flags;
  logic [NT-1:0] en;
  logic [NT-1:0] tick;
  logic [NT-1:0] reload;
  logic [NT-1:0] zero_evt;
  logic [CW-1:0] count [NT];
  logic [CW-1:0] latch [NT];
  logic          irq_hit;

  dt_regbus u_bus (
    .cs   (cs),
    .wr   (wr),
    .rd   (rd),
    .addr (addr),
    .stb  (stb)
  );

  dt_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (pulse_in),
    .strike (strike)
  );

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    if (g == TMR_A) begin : g_cfg
      assign tick[g]   = 1'b1;
      assign reload[g] = mode[g];
    end else begin : g_cfg
      assign tick[g]   = mode[g] ? strike : 1'b1;
      assign reload[g] = 1'b0;
    end

    dt_countdown u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick[g]),
      .reload    (reload[g]),
      .lat_lo_we (stb.lat_lo_we[g]),
      .lat_hi_we (stb.lat_hi_we[g]),
      .start     (stb.start[g]),
      .wdata     (wdata),
      .count     (count[g]),
      .latch     (latch[g]),
      .zero_evt  (zero_evt[g])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[g] <= 1'b0;
      else if (zero_evt[g])
        flags[g] <= 1'b1;
      else if (stb.start[g] || stb.rd_clr[g] || (stb.flag_we && wdata[g]))
        flags[g] <= 1'b0;
    end

    a_r7_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stb.rd_clr[g] && !zero_evt[g]) |=> !flags[g]);

    a_r3_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[g]) |-> $past(zero_evt[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      en   <= '0;
    end else begin
      if (stb.mode_we) mode <= wdata[NT-1:0];
      if (stb.en_we) begin
        if (wdata[EN_SET_BIT]) en <= en | wdata[NT-1:0];
        else                   en <= en & ~wdata[NT-1:0];
      end
    end
  end

  assign irq_hit = |(flags & en);
  assign irq_n   = ~irq_hit;

  always_comb begin
    rdata = '0;
    if (cs) begin
      case (addr)
        ADDR_A_CLO:  rdata = count[TMR_A][DW-1:0];
        ADDR_A_CHI:  rdata = count[TMR_A][CW-1:DW];
        ADDR_A_LLO:  rdata = latch[TMR_A][DW-1:0];
        ADDR_A_LHI:  rdata = latch[TMR_A][CW-1:DW];
        ADDR_B_CLO:  rdata = count[TMR_B][DW-1:0];
        ADDR_B_CHI:  rdata = count[TMR_B][CW-1:DW];
        ADDR_MODE:   rdata = DW'(mode);
        ADDR_FLAG: begin
          rdata = DW'(flags);
          rdata[IRQ_BIT] = irq_hit;
        end
        ADDR_ENABLE: rdata = DW'(en);
        default:     rdata = '0;
      endcase
    end
  end

  a_r8_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.en_we && wdata[EN_SET_BIT]) |=> (en & $past(wdata[NT-1:0])) == $past(wdata[NT-1:0]));

  a_r8_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.en_we && !wdata[EN_SET_BIT]) |=> (en & $past(wdata[NT-1:0])) == '0);

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> irq_n);
endmodule

// File: tb/test_dual_timer_unit.sv
module test_dual_timer_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pulse_in = 1'b1;
  logic       irq_n;
  int nchk = 0;
  int nbad = 0;

  always #5 clk = ~clk;

  dual_timer_unit i_dual_timer_unit (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata), .pulse_in(pulse_in), .irq_n(irq_n)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rdclr(input logic [3:0] a);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] v);
    cs = 1'b1; addr = a;
    #1 v = rdata;
    cs = 1'b0;
  endtask

  task automatic pulse();
    pulse_in = 1'b0; cycles(4);
    pulse_in = 1'b1; cycles(4);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 9; a++) begin
      peek(4'(a), v);
      chk("R1", $sformatf("reg %0d after reset", a), v, 0);
    end
    chk("R1", "irq_n after reset", irq_n, 1);
    cycles(5);
    peek(4'd0, v); chk("R1", "stopped A count", v, 0);
    peek(4'd5, v); chk("R1", "stopped B count", v, 0);
    chk("R10", "rdata with cs low", rdata, 0);
  endtask

  task automatic t_oneshot_a();
    logic [7:0] v;
    bus_wr(4'd8, 8'h81);
    bus_wr(4'd0, 8'd5);
    bus_wr(4'd1, 8'd0);
    peek(4'd0, v); chk("R2", "A loaded", v, 5);
    cycles(2);
    peek(4'd0, v); chk("R2", "A decremented", v, 3);
    cycles(3);
    peek(4'd7, v); chk("R3", "A flag one clock early", v[0], 0);
    chk("R9", "irq_n before zero", irq_n, 1);
    cycles(1);
    peek(4'd7, v); chk("R3", "A flag at N+1", v[0], 1);
    chk("R9", "flag reg irq bit", v[7], 1);
    chk("R9", "irq_n asserted", irq_n, 0);
    peek(4'd1, v); chk("R3", "A wrapped high byte", v, 8'hFF);
    bus_rdclr(4'd0);
    peek(4'd7, v); chk("R7", "A flag cleared by low read", v[0], 0);
    chk("R9", "irq_n released", irq_n, 1);
    cycles(65540);
    peek(4'd7, v); chk("R3", "A one-shot no second flag", v[0], 0);
  endtask

  task automatic t_freerun_a();
    logic [7:0] v;
    bus_wr(4'd6, 8'h01);
    bus_wr(4'd0, 8'd3);
    bus_wr(4'd1, 8'd0);
    cycles(4);
    peek(4'd7, v); chk("R4", "free-run first flag", v[0], 1);
    peek(4'd0, v); chk("R4", "reloaded count", v, 3);
    bus_wr(4'd7, 8'h01);
    peek(4'd7, v); chk("R7", "write-1 clears flag", v[0], 0);
    cycles(2);
    peek(4'd7, v); chk("R4", "no flag mid period", v[0], 0);
    cycles(1);
    peek(4'd7, v); chk("R4", "second period flag", v[0], 1);
    bus_wr(4'd2, 8'd9);
    peek(4'd0, v); chk("R4", "latch write leaves count", v, 2);
    peek(4'd2, v); chk("R10", "latch low readback", v, 9);
    cycles(3);
    peek(4'd0, v); chk("R4", "reload uses new latch", v, 9);
    bus_wr(4'd6, 8'h00);
    bus_wr(4'd8, 8'h01);
    peek(4'd8, v); chk("R8", "enable A cleared", v, 0);
    bus_wr(4'd7, 8'h03);
  endtask

  task automatic t_interval_b();
    logic [7:0] v;
    bus_wr(4'd4, 8'd4);
    bus_wr(4'd5, 8'd0);
    peek(4'd4, v); chk("R2", "B loaded", v, 4);
    cycles(4);
    peek(4'd7, v); chk("R5", "B flag early", v[1], 0);
    cycles(1);
    peek(4'd7, v); chk("R5", "B flag at N+1", v[1], 1);
    chk("R9", "disabled flag no irq", irq_n, 1);
    bus_wr(4'd8, 8'h82);
    peek(4'd8, v); chk("R8", "enable B set", v, 2);
    chk("R9", "enabled flag irq", irq_n, 0);
    bus_wr(4'd8, 8'h02);
    chk("R8", "enable clear drops irq", irq_n, 1);
    bus_rdclr(4'd4);
    peek(4'd7, v); chk("R7", "B flag cleared by low read", v[1], 0);
  endtask

  task automatic t_pulse_b();
    logic [7:0] v;
    bus_wr(4'd6, 8'h02);
    peek(4'd6, v); chk("R10", "mode readback", v, 2);
    bus_wr(4'd4, 8'd2);
    bus_wr(4'd5, 8'd0);
    cycles(10);
    peek(4'd4, v); chk("R6", "no edges no count", v, 2);
    pulse();
    peek(4'd4, v); chk("R6", "one edge", v, 1);
    pulse();
    peek(4'd4, v); chk("R6", "two edges", v, 0);
    peek(4'd7, v); chk("R6", "no flag after N edges", v[1], 0);
    pulse();
    peek(4'd7, v); chk("R6", "flag on N+1 edge", v[1], 1);
    peek(4'd5, v); chk("R6", "B wrapped high byte", v, 8'hFF);
    bus_wr(4'd4, 8'd1);
    bus_wr(4'd5, 8'd0);
    peek(4'd7, v); chk("R2", "start clears B flag", v[1], 0);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_oneshot_a();
    t_freerun_a();
    t_interval_b();
    t_pulse_b();
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule